// File: doc/BRIEF.md
# Sequentially Consistent Memory Issue Controller

This block sits between an in-order core's memory request queue and the core's private cache and shared-interconnect port. It takes one request at a time, either a load or a store. It holds further requests back until the current one has completed, and then reports the completion on a single in-order retire strobe. Because only one access is ever in flight, every ordering between loads and stores is kept: load then load, load then store, store then load, and store then store. A store's value is never passed directly to a later load; that load always reads through the cache.

A load completes when the cache returns its data. A store first looks up the cache. If the line is already held exclusive or modified, the store completes with no interconnect traffic. Otherwise the block raises an exclusive-ownership request towards the interconnect. In bus mode the store completes at the grant of that request. In network mode the store completes only once every peer cache controller and the memory controller have acknowledged it. The mode is sampled together with each request.

Top module: `sc_issue_ctrl`

## Requirements
- R1: `req_ready_o` is high only while no request is outstanding. It is high out of reset, goes low the cycle after a request is accepted, and returns high in the cycle that request retires.
- R2: After a load is accepted, `cache_req_valid_o` is high with `cache_req_store_o`=0 and the load's address. The load retires in the cycle after the edge where `cache_rsp_valid_i` is sampled high, with `retire_rdata_o` equal to `cache_rsp_rdata_i` and `retire_store_o`=0.
- R3: `cache_req_valid_o` and `bus_req_o` are never high unless an accepted request has not yet retired. A younger access therefore never reaches the cache or the interconnect before the older one completes.
- R4: After a store is accepted, the cache sees `cache_req_store_o`=1 with the store's address and data. If the response has `cache_rsp_excl_i`=1, the store retires the following cycle and `bus_req_o` never rises.
- R5: If the store's response has `cache_rsp_excl_i`=0, `bus_req_o` rises the next cycle and stays high until `bus_gnt_i`. In bus mode (`net_mode_i`=0 at acceptance), the store retires in the cycle after the grant edge.
- R6: In network mode (`net_mode_i`=1), a granted store retires in the cycle after the edge at which the total of set bits seen on `ack_i` since the grant reaches NPEER+1. Each bit of `ack_i` is one acknowledgement from one source, and any number of bits may be set in one cycle.
- R7: `ack_i` bits seen before the grant of the current store do not count toward its completion.
- R8: A load to the address of the previous store is still sent to the cache and retires with the cache's data, not the store data.
- R9: Each accepted request produces exactly one one-cycle `retire_valid_o` pulse carrying its tag. For a store, `retire_rdata_o` is 0.
- R10: During reset, `cache_req_valid_o`, `bus_req_o` and `retire_valid_o` are 0 and `req_ready_o` is 1.
- R11: While `cache_req_valid_o` is high and `cache_req_ready_i` is low, the request and its address are held. After the handshake edge, `cache_req_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| net_mode_i | input | 1 | Store completion mode, sampled at acceptance: 0 grant, 1 acknowledgements |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_store_i | input | 1 | 1 store, 0 load |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| req_tag_i | input | TW | Request tag |
| cache_req_valid_o | output | 1 | Cache access request |
| cache_req_ready_i | input | 1 | Cache accepts the access |
| cache_req_store_o | output | 1 | Access is a store |
| cache_req_addr_o | output | AW | Access address |
| cache_req_wdata_o | output | DW | Store data to cache |
| cache_rsp_valid_i | input | 1 | Cache response |
| cache_rsp_excl_i | input | 1 | Store hit a line held exclusive or modified |
| cache_rsp_rdata_i | input | DW | Load data |
| bus_req_o | output | 1 | Exclusive-ownership request to the interconnect |
| bus_gnt_i | input | 1 | Interconnect grant |
| ack_i | input | NPEER+1 | One acknowledgement bit per peer controller and memory |
| retire_valid_o | output | 1 | Retirement strobe |
| retire_tag_o | output | TW | Tag of the retiring request |
| retire_store_o | output | 1 | Retiring request was a store |
| retire_rdata_o | output | DW | Load data, 0 for stores |

## Verification
Every result of this block appears exactly one cycle after the edge of the event that completes the access: the cache response for a load or a store that hits an exclusive line, the grant in bus mode, or the acknowledgement that brings the count to NPEER+1 in network mode. The bench drives each event on a falling edge and samples at the next falling edge, which is the first cycle in which the result can be visible. At every falling edge in between, it checks that the retire strobe is still low and that request acceptance is still closed. Sweeps cover cache handshake and response delays, grant delays, acknowledgement rates from one to four bits per cycle, and acknowledgements sent early, before the grant.

// File: rtl/sc_issue_pkg.sv
package sc_issue_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LOAD,
    ST_WAIT_LOOKUP,
    ST_WAIT_BUS,
    ST_WAIT_ACKS
  } sc_state_e;
endpackage

// File: rtl/sc_ack_counter.sv
module sc_ack_counter #(
  parameter int NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            en_i,
  input  logic [NSRC-1:0] ack_i,
  output logic            done_o
);
  localparam int CW = $clog2(NSRC + 1);
  localparam logic [CW:0] FULL = (CW + 1)'(NSRC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q};
    for (int i = 0; i < NSRC; i++) begin
      sum = sum + (CW + 1)'(ack_i[i]);
    end
    cnt_d  = (sum >= FULL) ? FULL[CW-1:0] : sum[CW-1:0];
    done_o = en_i && (sum >= FULL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sc_issue_fsm.sv
module sc_issue_fsm
  import sc_issue_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_store_i,
  input  logic net_i,
  input  logic cache_req_ready_i,
  input  logic cache_rsp_valid_i,
  input  logic cache_rsp_excl_i,
  input  logic bus_gnt_i,
  input  logic acks_done_i,
  output logic idle_o,
  output logic cache_req_valid_o,
  output logic bus_req_o,
  output logic ack_clear_o,
  output logic ack_en_o,
  output logic done_o
);
  sc_state_e state_q, state_d;
  logic      sent_q;
  logic      rsp_ok;

  assign idle_o            = (state_q == ST_IDLE);
  assign cache_req_valid_o = ((state_q == ST_WAIT_LOAD) || (state_q == ST_WAIT_LOOKUP)) && !sent_q;
  assign bus_req_o         = (state_q == ST_WAIT_BUS);
  assign ack_en_o          = (state_q == ST_WAIT_ACKS);
  // response only counts once the access has been handed to the cache
  assign rsp_ok            = sent_q && cache_rsp_valid_i;

  always_comb begin
    state_d     = state_q;
    done_o      = 1'b0;
    ack_clear_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = start_store_i ? ST_WAIT_LOOKUP : ST_WAIT_LOAD;
      end
      ST_WAIT_LOAD: begin
        if (rsp_ok) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_LOOKUP: begin
        if (rsp_ok) begin
          if (cache_rsp_excl_i) begin
            done_o  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WAIT_BUS;
          end
        end
      end
      ST_WAIT_BUS: begin
        if (bus_gnt_i) begin
          if (net_i) begin
            ack_clear_o = 1'b1;
            state_d     = ST_WAIT_ACKS;
          end else begin
            done_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WAIT_ACKS: begin
        if (acks_done_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i)                                  sent_q <= 1'b0;
      else if (cache_req_valid_o && cache_req_ready_i) sent_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_retire_stage.sv
module sc_retire_stage #(
  parameter int TW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [TW-1:0] tag_i,
  input  logic          store_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic [TW-1:0] tag_o,
  output logic          store_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      store_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        tag_o   <= tag_i;
        store_o <= store_i;
        rdata_o <= store_i ? '0 : rdata_i;
      end
    end
  end
endmodule

// File: rtl/sc_issue_ctrl.sv
module sc_issue_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TW    = 4,
  parameter int NPEER = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          net_mode_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_store_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [TW-1:0] req_tag_i,
  output logic          cache_req_valid_o,
  input  logic          cache_req_ready_i,
  output logic          cache_req_store_o,
  output logic [AW-1:0] cache_req_addr_o,
  output logic [DW-1:0] cache_req_wdata_o,
  input  logic          cache_rsp_valid_i,
  input  logic          cache_rsp_excl_i,
  input  logic [DW-1:0] cache_rsp_rdata_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  input  logic [NPEER:0] ack_i,
  output logic          retire_valid_o,
  output logic [TW-1:0] retire_tag_o,
  output logic          retire_store_o,
  output logic [DW-1:0] retire_rdata_o
);
  localparam int NSRC = NPEER + 1;

  logic          idle, start, done;
  logic          ack_clear, ack_en, acks_done;
  logic          store_q, net_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] tag_q;

  assign req_ready_o = idle;
  assign start       = req_valid_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      net_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      tag_q   <= '0;
    end else if (start) begin
      store_q <= req_store_i;
      net_q   <= net_mode_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      tag_q   <= req_tag_i;
    end
  end

  assign cache_req_store_o = store_q;
  assign cache_req_addr_o  = addr_q;
  assign cache_req_wdata_o = wdata_q;

  sc_issue_fsm u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .start_i          (start),
    .start_store_i    (req_store_i),
    .net_i            (net_q),
    .cache_req_ready_i(cache_req_ready_i),
    .cache_rsp_valid_i(cache_rsp_valid_i),
    .cache_rsp_excl_i (cache_rsp_excl_i),
    .bus_gnt_i        (bus_gnt_i),
    .acks_done_i      (acks_done),
    .idle_o           (idle),
    .cache_req_valid_o(cache_req_valid_o),
    .bus_req_o        (bus_req_o),
    .ack_clear_o      (ack_clear),
    .ack_en_o         (ack_en),
    .done_o           (done)
  );

  sc_ack_counter #(.NSRC(NSRC)) u_acks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ack_clear),
    .en_i   (ack_en),
    .ack_i  (ack_i),
    .done_o (acks_done)
  );

  sc_retire_stage #(.TW(TW), .DW(DW)) u_retire (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .tag_i  (tag_q),
    .store_i(store_q),
    .rdata_i(cache_rsp_rdata_i),
    .valid_o(retire_valid_o),
    .tag_o  (retire_tag_o),
    .store_o(retire_store_o),
    .rdata_o(retire_rdata_o)
  );
endmodule

// File: rtl/sc_issue_chk.sv
module sc_issue_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          cache_req_valid_o,
  input logic          cache_req_ready_i,
  input logic [AW-1:0] cache_req_addr_o,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          retire_valid_o
);
  logic [1:0] out_q;
  logic       acc;

  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_q + {1'b0, acc} - {1'b0, retire_valid_o};
  end

  // R1
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= 2'd1);

  // R1
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q == 2'd1 && !retire_valid_o) |-> !req_ready_o);

  // R3
  no_stray_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_valid_o || bus_req_o) |-> (out_q == 2'd1));

  // R9
  retire_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> (out_q == 2'd1));

  // R9
  retire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |=> !retire_valid_o);

  // R11
  cache_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_valid_o && !cache_req_ready_i) |=> (cache_req_valid_o && $stable(cache_req_addr_o)));

  // R5
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);
endmodule

bind sc_issue_ctrl sc_issue_chk #(.AW(AW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .cache_req_valid_o(cache_req_valid_o),
  .cache_req_ready_i(cache_req_ready_i),
  .cache_req_addr_o (cache_req_addr_o),
  .bus_req_o        (bus_req_o),
  .bus_gnt_i        (bus_gnt_i),
  .retire_valid_o   (retire_valid_o)
);

// File: tb/sim_sc_issue_ctrl.sv
module sim_sc_issue_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, TW = 4, NPEER = 3;
  localparam int NSRC = NPEER + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic net_mode_i = 1'b0, req_valid_i = 1'b0, req_store_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [TW-1:0] req_tag_i = '0;
  logic cache_req_ready_i = 1'b0, cache_rsp_valid_i = 1'b0, cache_rsp_excl_i = 1'b0;
  logic [DW-1:0] cache_rsp_rdata_i = '0;
  logic bus_gnt_i = 1'b0;
  logic [NPEER:0] ack_i = '0;
  logic req_ready_o, cache_req_valid_o, cache_req_store_o, bus_req_o;
  logic [AW-1:0] cache_req_addr_o;
  logic [DW-1:0] cache_req_wdata_o, retire_rdata_o;
  logic retire_valid_o, retire_store_o;
  logic [TW-1:0] retire_tag_o;

  int nchk = 0, nfail = 0;
  int tagc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_issue_ctrl #(.AW(AW), .DW(DW), .TW(TW), .NPEER(NPEER)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .net_mode_i(net_mode_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_store_i(req_store_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_tag_i(req_tag_i),
    .cache_req_valid_o(cache_req_valid_o), .cache_req_ready_i(cache_req_ready_i),
    .cache_req_store_o(cache_req_store_o), .cache_req_addr_o(cache_req_addr_o),
    .cache_req_wdata_o(cache_req_wdata_o), .cache_rsp_valid_i(cache_rsp_valid_i),
    .cache_rsp_excl_i(cache_rsp_excl_i), .cache_rsp_rdata_i(cache_rsp_rdata_i),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .ack_i(ack_i),
    .retire_valid_o(retire_valid_o), .retire_tag_o(retire_tag_o),
    .retire_store_o(retire_store_o), .retire_rdata_o(retire_rdata_o)
  );

  task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // present a request, return at the negedge after acceptance
  task automatic send(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [TW-1:0] t, input bit mode);
    @(negedge clk);
    check("R1 ready when idle", req_ready_o, 1);
    check("R3 no cache access when idle", cache_req_valid_o, 0);
    req_valid_i = 1'b1; req_store_i = st; req_addr_i = a; req_wdata_i = d;
    req_tag_i = t; net_mode_i = mode;
    @(negedge clk);
    req_valid_i = 1'b0; req_addr_i = ~a; req_wdata_i = ~d; net_mode_i = ~mode;
    check("R1 ready low while busy", req_ready_o, 0);
    check(st ? "R4 store to cache" : "R2 load to cache", cache_req_valid_o, 1);
    check(st ? "R4 store bit" : "R2 load bit", cache_req_store_o, st);
    check(st ? "R4 addr" : "R2 addr", cache_req_addr_o, a);
    if (st) check("R4 wdata", cache_req_wdata_o, d);
  endtask

  task automatic handshake(input int lat, input logic [AW-1:0] a);
    for (int i = 0; i < lat; i++) begin
      check("R11 held valid", cache_req_valid_o, 1);
      check("R11 held addr", cache_req_addr_o, a);
      @(negedge clk);
    end
    cache_req_ready_i = 1'b1;
    @(negedge clk);
    cache_req_ready_i = 1'b0;
    check("R11 drop after handshake", cache_req_valid_o, 0);
  endtask

  task automatic respond(input int lat, input bit excl, input logic [DW-1:0] d);
    for (int i = 0; i < lat; i++) begin
      check("R2 no early retire", retire_valid_o, 0);
      check("R1 still busy", req_ready_o, 0);
      @(negedge clk);
    end
    cache_rsp_valid_i = 1'b1; cache_rsp_excl_i = excl; cache_rsp_rdata_i = d;
    @(negedge clk);
    cache_rsp_valid_i = 1'b0; cache_rsp_excl_i = 1'b0; cache_rsp_rdata_i = ~d;
  endtask

  task automatic expect_retire(input string rq, input logic [TW-1:0] t, input bit st,
                               input logic [DW-1:0] d);
    check({rq, " R9 retire strobe"}, retire_valid_o, 1);
    check({rq, " R9 tag"}, retire_tag_o, t);
    check({rq, " R9 store flag"}, retire_store_o, st);
    check({rq, " data"}, retire_rdata_o, st ? 0 : d);
    check({rq, " R1 ready at retire"}, req_ready_o, 1);
    @(negedge clk);
    check("R9 single pulse", retire_valid_o, 0);
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int hl, input int rl, input string rq);
    logic [TW-1:0] t = TW'(tagc++);
    send(1'b0, a, 0, t, 1'b0);
    handshake(hl, a);
    respond(rl, 1'b0, d);
    expect_retire(rq, t, 1'b0, d);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit mode,
                          input bit excl, input int gl, input int rate, input bit early);
    logic [TW-1:0] t = TW'(tagc++);
    int left;
    send(1'b1, a, d, t, mode);
    handshake(1, a);
    respond(1, excl, 8'h5C);
    if (excl) begin
      check("R4 no bus on exclusive hit", bus_req_o, 0);
      expect_retire("R4", t, 1'b1, 0);
      return;
    end
    check("R5 bus request raised", bus_req_o, 1);
    check("R5 no retire before grant", retire_valid_o, 0);
    for (int i = 0; i < gl; i++) begin
      if (early) ack_i = '1;
      @(negedge clk);
      check("R5 bus request held", bus_req_o, 1);
      check("R5 no retire before grant", retire_valid_o, 0);
    end
    ack_i = '0;
    bus_gnt_i = 1'b1;
    @(negedge clk);
    bus_gnt_i = 1'b0;
    check("R5 bus request dropped", bus_req_o, 0);
    if (!mode) begin
      expect_retire("R5", t, 1'b1, 0);
      return;
    end
    check(early ? "R7 early acks ignored" : "R6 no retire at grant", retire_valid_o, 0);
    left = NSRC;
    while (left > 0) begin
      int n = (rate < left) ? rate : left;
      logic [NPEER:0] v = '0;
      for (int k = 0; k < n; k++) v[NSRC - left + k] = 1'b1;
      ack_i = v;
      @(negedge clk);
      ack_i = '0;
      left -= n;
      if (left > 0) begin
        check(early ? "R7 acks counted after grant only" : "R6 wait for all acks",
              retire_valid_o, 0);
        check("R6 still busy", req_ready_o, 0);
      end
    end
    expect_retire("R6", t, 1'b1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog got=%0h exp=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 reset ready", req_ready_o, 1);
    check("R10 reset cache req", cache_req_valid_o, 0);
    check("R10 reset bus req", bus_req_o, 0);
    check("R10 reset retire", retire_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int hl = 0; hl < 3; hl++)
      for (int rl = 0; rl < 3; rl++)
        do_load(AW'(hl * 16 + rl), DW'(hl * 37 + rl * 11 + 1), hl, rl, "R2 load sweep");

    for (int m = 0; m < 2; m++)
      for (int ex = 0; ex < 2; ex++)
        for (int gl = 0; gl < 3; gl++)
          for (int r = 1; r <= NSRC; r++)
            for (int e = 0; e < 2; e++)
              if ((m == 1 && ex == 0) || (r == 1 && e == 0))
                do_store(AW'(m * 64 + gl * 8 + r), DW'(r * 19 + gl), m[0], ex[0], gl, r, e[0]);

    // R8 load after store to the same address reads the cache
    do_store(8'h5A, 8'hAA, 1'b0, 1'b1, 0, 1, 1'b0);
    do_load(8'h5A, 8'h33, 0, 0, "R8 no forwarding");
    do_store(8'h5A, 8'hAA, 1'b1, 1'b0, 1, 2, 1'b0);
    do_load(8'h5A, 8'h44, 1, 1, "R8 no forwarding net");
    // R3 load-load back to back
    do_load(8'h01, 8'h11, 0, 2, "R3 older miss");
    do_load(8'h02, 8'h22, 0, 0, "R3 younger hit");

    summary();
    $finish;
  end
endmodule